// File: doc/BRIEF.md
# Drawing Command Queue Front End

This block sits between the host register port of a drawing accelerator and its drawing engines. Each host write to an ordinary register address is turned into a command made of that address and its 32-bit data. The command is queued and then handed, in order, to the engines over a valid/ready port. One address is reserved for a status word. A host read of that address returns the free queue space, two busy indications and two sticky error flags.

Software is expected to poll the free count before it writes. It sends a burst only when the count shows room, so the host bus never stalls. A write that arrives while the queue is full is discarded, and the overflow flag records it. A read of any other register while commands are still waiting sets the read-error flag. Both error flags stay set until software writes a one to them at the status address.

Top module: `gfx_cmd_queue`

## Requirements
- R1: Commands leave on `cmd_addr`/`cmd_data` in the order they were written. `cmd_valid` is high exactly while at least one command is held. While `cmd_ready` is low, the head command stays unchanged.
- R2: Bits 11:0 of the status word give the number of free entries, DEPTH minus the entries occupied at the clock edge of the read. The count never exceeds the true space.
- R3: A command write while the queue is full is discarded, leaving the queue unchanged, and it sets sticky bit 31 (overflow).
- R4: A read of a non-status address while the queue is not empty sets sticky bit 30 (read error). The same read with an empty queue leaves the flag as it was.
- R5: A write to the status address clears bit 30 and/or bit 31 wherever the write data has a one in that position. Zero bits leave the flags alone, and the write is never queued.
- R6: Status bit 24 is `mem_busy_in` OR queue-not-empty. Status bit 25 is `raster_busy_in` OR queue-not-empty. All other status bits read as zero.
- R7: A read never enters the queue. `host_rdata` is registered and changes on the clock edge of the read. A status read loads the status word, and a non-status read loads zero.
- R8: After synchronous reset the queue is empty, both error flags are clear and `host_rdata` is zero.
- R9: A read strobe asserted in the same cycle as a write strobe is ignored, and `host_rdata` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr_en | input | 1 | Host write strobe |
| host_rd_en | input | 1 | Host read strobe |
| host_addr | input | ADDR_W | Host register address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Registered host read data |
| mem_busy_in | input | 1 | Memory-side engine busy |
| raster_busy_in | input | 1 | Raster-side engine busy |
| cmd_valid | output | 1 | A queued command is offered |
| cmd_ready | input | 1 | Engine accepts the offered command |
| cmd_addr | output | ADDR_W | Register address of the head command |
| cmd_data | output | 32 | Data of the head command |

## Verification
The assertions check the following on every cycle:
- the occupancy bound;
- that a stalled head command stays stable;
- that overflow and read-error events set their flags on the next edge;
- that a flag stays set until a status write;
- that a status read taken with commands pending shows both busy bits and a free count no larger than the depth.

The exact free count after a mixed series of writes and pops can only be shown by the bench's scenarios. The same holds for the order of the drained commands, for the loss of the one write that hit a full queue, and for the per-bit effect of write-one-to-clear.

// File: rtl/cmdq_pkg.sv
`timescale 1ns/1ps
package cmdq_pkg;

    localparam int unsigned FREE_W       = 12;
    localparam int unsigned BIT_MEM_BUSY = 24;
    localparam int unsigned BIT_RAS_BUSY = 25;
    localparam int unsigned BIT_RD_ERR   = 30;
    localparam int unsigned BIT_OVF      = 31;

    typedef enum logic [2:0] {
        HOP_NONE,
        HOP_PUSH,
        HOP_STAT_WR,
        HOP_STAT_RD,
        HOP_REG_RD
    } host_op_e;

    typedef struct packed {
        logic ovf;
        logic rd_err;
    } err_flags_t;

    function automatic host_op_e decode_op(logic wr, logic rd, logic is_stat);
        if (wr)
            return is_stat ? HOP_STAT_WR : HOP_PUSH;
        if (rd)
            return is_stat ? HOP_STAT_RD : HOP_REG_RD;
        return HOP_NONE;
    endfunction

    function automatic logic [31:0] pack_status(logic [FREE_W-1:0] free,
                                                logic mem_busy,
                                                logic ras_busy,
                                                err_flags_t errs);
        logic [31:0] w;
        w = '0;
        w[FREE_W-1:0]   = free;
        w[BIT_MEM_BUSY] = mem_busy;
        w[BIT_RAS_BUSY] = ras_busy;
        w[BIT_RD_ERR]   = errs.rd_err;
        w[BIT_OVF]      = errs.ovf;
        return w;
    endfunction

endpackage

// File: rtl/cmdq_host_decode.sv
`timescale 1ns/1ps
module cmdq_host_decode
    import cmdq_pkg::*;
#(
    parameter int unsigned ADDR_W      = 8,
    parameter logic [ADDR_W-1:0] STATUS_ADDR = '1
) (
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    output host_op_e          op
);
    logic is_stat;

    assign is_stat = (addr == STATUS_ADDR);
    assign op      = decode_op(wr_en, rd_en, is_stat);

endmodule

// File: rtl/cmdq_fifo.sv
`timescale 1ns/1ps
module cmdq_fifo #(
    parameter int unsigned DEPTH = 64,
    parameter int unsigned WIDTH = 40,
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push_req,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop_req,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic             full,
    output logic [CNT_W-1:0] level
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             do_push, do_pop;

    assign empty   = (level == '0);
    assign full    = (level == CNT_W'(DEPTH));
    assign do_push = push_req && !full;
    assign do_pop  = pop_req && !empty;
    assign head    = mem[rd_ptr];

    function automatic logic [PTR_W-1:0] bump(logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push)
            mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (do_push)
                wr_ptr <= bump(wr_ptr);
            if (do_pop)
                rd_ptr <= bump(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        level <= CNT_W'(DEPTH)) else $error("occupancy above depth"); // R3

    AST_HOLD_WHEN_STALLED: assert property (@(posedge clk) disable iff (rst)
        (!empty && !pop_req) |=> (!empty && $stable(head))) else $error("head moved while stalled"); // R1

    AST_FULL_DROP: assert property (@(posedge clk) disable iff (rst)
        (full && push_req && !pop_req) |=> (full && $stable(head))) else $error("write into full queue"); // R3

endmodule

// File: rtl/cmdq_status.sv
`timescale 1ns/1ps
module cmdq_status
    import cmdq_pkg::*;
#(
    parameter int unsigned DEPTH = 64,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  host_op_e         op,
    input  logic             clr_ovf,
    input  logic             clr_rd_err,
    input  logic             ovf_evt,
    input  logic             rd_err_evt,
    input  logic [CNT_W-1:0] level,
    input  logic             empty,
    input  logic             mem_busy_in,
    input  logic             raster_busy_in,
    output logic [31:0]      rdata
);
    err_flags_t        err_q;
    logic [FREE_W-1:0] free_cnt;
    logic [31:0]       status_word;
    logic              stat_wr;

    assign stat_wr     = (op == HOP_STAT_WR);
    assign free_cnt    = FREE_W'(DEPTH) - FREE_W'(level);
    assign status_word = pack_status(free_cnt,
                                     mem_busy_in    || !empty,
                                     raster_busy_in || !empty,
                                     err_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q <= '0;
        end else begin
            err_q.ovf    <= (err_q.ovf    && !(stat_wr && clr_ovf))    || ovf_evt;
            err_q.rd_err <= (err_q.rd_err && !(stat_wr && clr_rd_err)) || rd_err_evt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata <= '0;
        else if (op == HOP_STAT_RD)
            rdata <= status_word;
        else if (op == HOP_REG_RD)
            rdata <= '0;
    end

    AST_OVF_SET: assert property (@(posedge clk) disable iff (rst)
        ovf_evt |=> err_q.ovf) else $error("overflow not flagged"); // R3

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        (err_q.ovf && !stat_wr) |=> err_q.ovf) else $error("overflow flag lost"); // R3

    AST_RDERR_SET: assert property (@(posedge clk) disable iff (rst)
        rd_err_evt |=> err_q.rd_err) else $error("read error not flagged"); // R4

    AST_RDERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (err_q.rd_err && !stat_wr) |=> err_q.rd_err) else $error("read error flag lost"); // R4

    AST_FREE_BOUND: assert property (@(posedge clk) disable iff (rst)
        (op == HOP_STAT_RD) |=> (rdata[FREE_W-1:0] <= FREE_W'(DEPTH))) else $error("free count above depth"); // R2

    AST_BUSY_PENDING: assert property (@(posedge clk) disable iff (rst)
        (op == HOP_STAT_RD && !empty) |=> (rdata[BIT_MEM_BUSY] && rdata[BIT_RAS_BUSY])) else $error("busy clear with pending work"); // R6

endmodule

// File: rtl/gfx_cmd_queue.sv
`timescale 1ns/1ps
module gfx_cmd_queue
    import cmdq_pkg::*;
#(
    parameter int unsigned DEPTH  = 64,
    parameter int unsigned ADDR_W = 8,
    parameter logic [ADDR_W-1:0] STATUS_ADDR = 8'hC0,
    localparam int unsigned ENTRY_W = ADDR_W + 32,
    localparam int unsigned CNT_W   = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_wr_en,
    input  logic              host_rd_en,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [31:0]       host_wdata,
    output logic [31:0]       host_rdata,
    input  logic              mem_busy_in,
    input  logic              raster_busy_in,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [31:0]       cmd_data
);
    host_op_e           op;
    logic               q_empty, q_full;
    logic [CNT_W-1:0]   q_level;
    logic [ENTRY_W-1:0] q_head;
    logic               push_req;

    cmdq_host_decode #(
        .ADDR_W      (ADDR_W),
        .STATUS_ADDR (STATUS_ADDR)
    ) u_dec (
        .wr_en (host_wr_en),
        .rd_en (host_rd_en),
        .addr  (host_addr),
        .op    (op)
    );

    assign push_req = (op == HOP_PUSH);

    cmdq_fifo #(
        .DEPTH (DEPTH),
        .WIDTH (ENTRY_W)
    ) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .push_req  (push_req),
        .push_data ({host_addr, host_wdata}),
        .pop_req   (cmd_ready),
        .head      (q_head),
        .empty     (q_empty),
        .full      (q_full),
        .level     (q_level)
    );

    assign cmd_valid = !q_empty;
    assign cmd_addr  = q_head[ENTRY_W-1:32];
    assign cmd_data  = q_head[31:0];

    cmdq_status #(
        .DEPTH (DEPTH)
    ) u_stat (
        .clk            (clk),
        .rst            (rst),
        .op             (op),
        .clr_ovf        (host_wdata[BIT_OVF]),
        .clr_rd_err     (host_wdata[BIT_RD_ERR]),
        .ovf_evt        (push_req && q_full),
        .rd_err_evt     ((op == HOP_REG_RD) && !q_empty),
        .level          (q_level),
        .empty          (q_empty),
        .mem_busy_in    (mem_busy_in),
        .raster_busy_in (raster_busy_in),
        .rdata          (host_rdata)
    );

    AST_STAT_WR_NOT_QUEUED: assert property (@(posedge clk) disable iff (rst)
        (op == HOP_STAT_WR && q_empty && !cmd_ready) |=> !cmd_valid) else $error("status write queued"); // R5

    AST_READ_NOT_QUEUED: assert property (@(posedge clk) disable iff (rst)
        ((op == HOP_STAT_RD || op == HOP_REG_RD) && q_empty) |=> !cmd_valid) else $error("read queued"); // R7

endmodule

// File: tb/gfx_cmd_queue_tb.sv
`timescale 1ns/1ps
module gfx_cmd_queue_tb;

    localparam int unsigned DEPTH  = 64;
    localparam int unsigned ADDR_W = 8;
    localparam logic [7:0]  STAT   = 8'hC0;
    localparam int unsigned NVEC   = 6;
    localparam logic [39:0] VEC [NVEC] = '{
        {8'h10, 32'hDEAD_0001}, {8'h11, 32'h0000_0000}, {8'h20, 32'hFFFF_FFFF},
        {8'h07, 32'h1234_5678}, {8'hBF, 32'h8000_0001}, {8'h10, 32'h5A5A_A5A5}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              host_wr_en = 1'b0, host_rd_en = 1'b0;
    logic [ADDR_W-1:0] host_addr = '0;
    logic [31:0]       host_wdata = '0;
    logic [31:0]       host_rdata;
    logic              mem_busy_in = 1'b0, raster_busy_in = 1'b0;
    logic              cmd_valid, cmd_ready = 1'b0;
    logic [ADDR_W-1:0] cmd_addr;
    logic [31:0]       cmd_data;

    int checks = 0;
    int fails  = 0;
    logic [31:0] rd;

    always #2.5 clk = ~clk;

    gfx_cmd_queue #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .STATUS_ADDR(STAT)) u_dut (
        .clk(clk), .rst(rst),
        .host_wr_en(host_wr_en), .host_rd_en(host_rd_en),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .mem_busy_in(mem_busy_in), .raster_busy_in(raster_busy_in),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data)
    );

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        host_wr_en = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr_en = 1'b0;
    endtask

    task automatic rdreg(logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        host_rd_en = 1'b1; host_addr = a;
        @(negedge clk);
        host_rd_en = 1'b0;
        d = host_rdata;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        chk("R8 valid after reset", {63'd0, cmd_valid}, 64'd0);
        chk("R8 rdata after reset", {32'd0, host_rdata}, 64'd0);
        rdreg(STAT, rd);
        chk("R8 R2 status after reset", {32'd0, rd}, 64'h40);

        // stimulus table: queue each command, track the free count
        for (int i = 0; i < NVEC; i++) begin
            wr(VEC[i][39:32], VEC[i][31:0]);
            rdreg(STAT, rd);
            chk("R2 R6 status while queuing", {32'd0, rd},
                {32'd0, 32'h0300_0000 | (32'(DEPTH) - 32'(i + 1))});
        end
        chk("R1 head offered", {23'd0, cmd_valid, cmd_addr, cmd_data}, {24'd1, VEC[0]});
        repeat (3) @(negedge clk);
        chk("R1 head held while stalled", {23'd0, cmd_valid, cmd_addr, cmd_data}, {24'd1, VEC[0]});

        for (int i = 0; i < NVEC; i++) begin
            chk("R1 drain order", {23'd0, cmd_valid, cmd_addr, cmd_data}, {24'd1, VEC[i]});
            cmd_ready = 1'b1;
            @(negedge clk);
            cmd_ready = 1'b0;
            if (i == 1) begin
                rdreg(STAT, rd);
                chk("R2 free after partial drain", {32'd0, rd}, 64'h0300_003C);
            end
        end
        chk("R1 valid low when drained", {63'd0, cmd_valid}, 64'd0);

        // busy inputs with an empty queue
        mem_busy_in = 1'b1;
        rdreg(STAT, rd);
        chk("R6 memory busy only", {32'd0, rd}, 64'h0100_0040);
        mem_busy_in = 1'b0; raster_busy_in = 1'b1;
        rdreg(STAT, rd);
        chk("R6 raster busy only", {32'd0, rd}, 64'h0200_0040);
        raster_busy_in = 1'b0;

        // read together with write is ignored; status write is not queued
        @(negedge clk);
        host_wr_en = 1'b1; host_rd_en = 1'b1; host_addr = STAT; host_wdata = 32'h0;
        @(negedge clk);
        host_wr_en = 1'b0; host_rd_en = 1'b0;
        chk("R9 rdata kept on write+read", {32'd0, host_rdata}, 64'h0200_0040);
        chk("R5 status write not queued", {63'd0, cmd_valid}, 64'd0);

        // fill completely, then overrun
        for (int i = 0; i < DEPTH; i++)
            wr(8'(i), 32'h1000 + 32'(i));
        rdreg(STAT, rd);
        chk("R2 full shows zero free", {32'd0, rd}, 64'h0300_0000);
        wr(8'h05, 32'h0000_9999);
        rdreg(STAT, rd);
        chk("R3 overflow flag set", {32'd0, rd}, 64'h8300_0000);
        rdreg(8'h05, rd);
        chk("R7 non-status read returns zero", {32'd0, rd}, 64'd0);
        rdreg(STAT, rd);
        chk("R4 read error set with pending work", {32'd0, rd}, 64'hC300_0000);
        wr(STAT, 32'h8000_0000);
        rdreg(STAT, rd);
        chk("R5 clear overflow only", {32'd0, rd}, 64'h4300_0000);
        wr(STAT, 32'h0000_0000);
        rdreg(STAT, rd);
        chk("R5 zero write keeps flag", {32'd0, rd}, 64'h4300_0000);

        cmd_ready = 1'b1;
        for (int i = 0; i < DEPTH; i++) begin
            if (cmd_data !== 32'h1000 + 32'(i) || cmd_valid !== 1'b1)
                chk("R3 drained entry after overrun", {31'd0, cmd_valid, cmd_data},
                    {31'd0, 1'b1, 32'h1000 + 32'(i)});
            @(negedge clk);
        end
        cmd_ready = 1'b0;
        chk("R3 dropped write absent", {63'd0, cmd_valid}, 64'd0);

        wr(STAT, 32'h4000_0000);
        rdreg(STAT, rd);
        chk("R5 clear read error", {32'd0, rd}, 64'h0000_0040);
        rdreg(8'h05, rd);
        rdreg(STAT, rd);
        chk("R4 empty read leaves flag clear", {32'd0, rd}, 64'h0000_0040);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule